// File: doc/BRIEF.md
# Wide-Bus Register Bank Bridge

This block sits between a 64-bit processor data port and a bank of 32-bit control registers. Every 64-bit word offset on the bus covers a pair of adjacent 32-bit registers, an even one and an odd one. The bus lane mask decides which register of the pair a given access reaches and which half of the 64-bit bus carries its data. A mask that enables only the low 32 bits reaches the odd register, with its data in bits 63:32. Every other mask reaches the even register, with its data in bits 31:0.

Writes never replace a stored value. The selected 32-bit data is OR-ed into the register, so a bit that has been set stays set until the next reset. Reset clears the whole bank and then presets a few identification words. Which words are preset is chosen by a profile parameter: a system profile that carries a bus-version word, and a graphics profile that carries a device identifier and a revision. Read data is registered. Offsets past the end of the bank read as zero, and writes to them are dropped.

Top module: `wide_reg_bridge`

## Requirements
- R1: While `rst` is high, every register is loaded with its profile reset value, which is zero except for the preset words of R8 and R9, and `rd_data` is cleared to zero. A later reset clears any bits that writes have set.
- R2: With `lane_mask` equal to 64'hFFFF_FFFF_FFFF_FFFF, an access reaches register 2*`word_off`. A read returns that register in `rd_data[31:0]`, with `rd_data[63:32]` zero.
- R3: With `lane_mask` equal to 64'h0000_0000_FFFF_FFFF, an access reaches register 2*`word_off`+1. Write data is taken from `wr_data[63:32]`, and a read returns the register in `rd_data[63:32]`, with `rd_data[31:0]` zero.
- R4: A write stores old value OR the selected 32-bit data lane. The bits of `wr_data` outside that lane have no effect.
- R5: Writing zero bits never clears a bit that is already set.
- R6: `rd_data` takes the read result on the clock edge that samples `rd_en` high, and holds its value while `rd_en` is low.
- R7: An access whose register index is NUM_REGS or higher reads as zero and changes no register. In particular, it does not alias onto a lower register.
- R8: With the system profile, register 0x27 resets to 32'h0000_0008, which is reached at `word_off` 0x13 with the low-lane mask.
- R9: With the graphics profile, register 0 resets to 32'h17FD_11DB and register 1 resets to 32'h0000_0001.
- R10: Any mask other than the exact low-lane mask, for example 64'hFFFF_FFFF_0000_0000, falls back to the even register with data in bits 31:0.
- R11: When `rd_en` and `wr_en` are both high on the same register in one cycle, `rd_data` returns the value from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_off | input | OFF_W | 64-bit word offset |
| lane_mask | input | 64 | Bus lane mask |
| wr_data | input | 64 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Registered read data |

## Verification
The bench goes after the steering corners. A design that ignored the mask would return odd-register data in the low lane, or write the low half of `wr_data` into the odd register. A design that treated the upper-lane mask as special would miss the even-register fallback. A design that replaced stored values instead of merging them would lose sticky bits when later writes carry zeros. The bench also drives offsets just past the bank, where a truncated index would alias onto register 0. It drives a read and a write to one register in the same cycle, where a bypass would return the new value. Finally it checks the preset identification words of both profiles, which an all-zero reset would miss.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam logic [63:0] LOW_LANE_MASK = 64'h0000_0000_FFFF_FFFF;

    localparam int unsigned BUSVER_IDX = 32'h27;
    localparam logic [31:0] BUSVER_VAL = 32'h0000_0008;
    localparam logic [31:0] DEVID_VAL  = 32'h17FD_11DB;
    localparam logic [31:0] DEVREV_VAL = 32'h0000_0001;

    typedef enum logic [1:0] {
        PROFILE_BLANK    = 2'd0,
        PROFILE_SYSTEM   = 2'd1,
        PROFILE_GRAPHICS = 2'd2
    } profile_e;

    typedef struct packed {
        logic hi;
        logic hit;
    } lane_sel_t;

    function automatic logic [31:0] reset_word(profile_e p, int unsigned idx);
        logic [31:0] v;
        v = 32'h0;
        case (p)
            PROFILE_SYSTEM:   if (idx == BUSVER_IDX) v = BUSVER_VAL;
            PROFILE_GRAPHICS: begin
                if (idx == 0) v = DEVID_VAL;
                if (idx == 1) v = DEVREV_VAL;
            end
            default:          v = 32'h0;
        endcase
        return v;
    endfunction

    function automatic logic [31:0] pick_lane(logic [63:0] data, logic hi);
        return hi ? data[63:32] : data[31:0];
    endfunction

    function automatic logic [63:0] place_lane(logic [31:0] word, logic hi);
        return hi ? {word, 32'h0} : {32'h0, word};
    endfunction

endpackage

// File: rtl/lane_steer.sv
module lane_steer
    import bridge_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int OFF_W    = 8,
    localparam int IDX_W   = OFF_W + 1
)(
    input  logic [OFF_W-1:0] word_off,
    input  logic [63:0]      lane_mask,
    output logic [IDX_W-1:0] idx,
    output lane_sel_t        sel
);
    always_comb begin
        sel.hi  = (lane_mask == LOW_LANE_MASK);
        idx     = {word_off, sel.hi};
        sel.hit = ({1'b0, idx} < (IDX_W + 1)'(NUM_REGS));
    end
endmodule

// File: rtl/reg_store.sv
module reg_store
    import bridge_pkg::*;
#(
    parameter int       NUM_REGS = 128,
    parameter int       IDX_W    = 9,
    parameter profile_e PROFILE  = PROFILE_SYSTEM
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  lane_sel_t        sel,
    input  logic [63:0]      wr_data,
    output logic [31:0]      regs [NUM_REGS]
);
    logic [31:0] wr_word;

    always_comb wr_word = pick_lane(wr_data, sel.hi);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic do_merge;
        always_comb do_merge = wr_en && sel.hit && (idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= reset_word(PROFILE, i);
            else if (do_merge)
                regs[i] <= regs[i] | wr_word;
        end
    end
endmodule

// File: rtl/read_port.sv
module read_port
    import bridge_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int IDX_W    = 9,
    localparam int LIDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  lane_sel_t        sel,
    input  logic [31:0]      regs [NUM_REGS],
    output logic [63:0]      rd_data
);
    logic [LIDX_W-1:0] lidx;
    logic [63:0]       rd_next;

    always_comb begin
        lidx    = LIDX_W'(idx);
        rd_next = sel.hit ? place_lane(regs[lidx], sel.hi) : 64'h0;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= 64'h0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import bridge_pkg::*;
#(
    parameter int       NUM_REGS = 128,
    parameter int       OFF_W    = 8,
    parameter profile_e PROFILE  = PROFILE_SYSTEM,
    localparam int      IDX_W    = OFF_W + 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [OFF_W-1:0] word_off,
    input  logic [63:0]      lane_mask,
    input  logic [63:0]      wr_data,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [63:0]      rd_data
);
    logic [IDX_W-1:0] idx;
    lane_sel_t        sel;
    logic [31:0]      regs [NUM_REGS];

    lane_steer #(.NUM_REGS(NUM_REGS), .OFF_W(OFF_W)) u_steer (
        .word_off (word_off),
        .lane_mask(lane_mask),
        .idx      (idx),
        .sel      (sel)
    );

    reg_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .PROFILE(PROFILE)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .idx    (idx),
        .sel    (sel),
        .wr_data(wr_data),
        .regs   (regs)
    );

    read_port #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_read (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .idx    (idx),
        .sel    (sel),
        .regs   (regs),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker
    import bridge_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int OFF_W    = 8
)(
    input logic             clk,
    input logic             rst,
    input logic [OFF_W-1:0] word_off,
    input logic [63:0]      lane_mask,
    input logic             rd_en,
    input logic [63:0]      rd_data
);
    logic          armed;
    logic [OFF_W:0] chk_idx;
    logic          chk_out;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    always_comb begin
        chk_idx = (OFF_W + 1)'(word_off) * 2 + ((lane_mask == LOW_LANE_MASK) ? 1 : 0);
        chk_out = ({1'b0, chk_idx} >= (OFF_W + 2)'(NUM_REGS));
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        armed && !rd_en |=> $stable(rd_data));

    assert_full_lane_R2: assert property (@(posedge clk) disable iff (rst)
        armed && rd_en && lane_mask == 64'hFFFF_FFFF_FFFF_FFFF |=> rd_data[63:32] == 32'h0);

    assert_odd_lane_R3: assert property (@(posedge clk) disable iff (rst)
        armed && rd_en && lane_mask == LOW_LANE_MASK |=> rd_data[31:0] == 32'h0);

    assert_fallback_R10: assert property (@(posedge clk) disable iff (rst)
        armed && rd_en && lane_mask != LOW_LANE_MASK |=> rd_data[63:32] == 32'h0);

    assert_out_of_range_R7: assert property (@(posedge clk) disable iff (rst)
        armed && rd_en && chk_out |=> rd_data == 64'h0);
endmodule

bind wide_reg_bridge bridge_checker #(.NUM_REGS(NUM_REGS), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .word_off (word_off),
    .lane_mask(lane_mask),
    .rd_en    (rd_en),
    .rd_data  (rd_data)
);

// File: tb/wide_reg_bridge_test.sv
module wide_reg_bridge_test;
    import bridge_pkg::*;

    localparam logic [63:0] M_FULL = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] M_LOW  = 64'h0000_0000_FFFF_FFFF;
    localparam logic [63:0] M_HIGH = 64'hFFFF_FFFF_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  word_off = '0;
    logic [63:0] lane_mask = '0;
    logic [63:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [63:0] rd_data, rd_data_alt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wide_reg_bridge #(.NUM_REGS(128), .OFF_W(8), .PROFILE(PROFILE_SYSTEM)) uut (
        .clk(clk), .rst(rst), .word_off(word_off), .lane_mask(lane_mask),
        .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data));

    wide_reg_bridge #(.NUM_REGS(128), .OFF_W(8), .PROFILE(PROFILE_GRAPHICS)) uut_alt (
        .clk(clk), .rst(rst), .word_off(word_off), .lane_mask(lane_mask),
        .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data_alt));

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(logic [7:0] off, logic [63:0] m, logic [63:0] d);
        @(negedge clk);
        word_off = off; lane_mask = m; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [7:0] off, logic [63:0] m);
        @(negedge clk);
        word_off = off; lane_mask = m; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset_values();
        check("R1 rd_data after reset", rd_data, 64'h0);
        do_read(8'h00, M_FULL);
        check("R1 system reg0", rd_data, 64'h0);
        check("R9 graphics reg0", rd_data_alt, 64'h0000_0000_17FD_11DB);
        do_read(8'h00, M_LOW);
        check("R9 graphics reg1", rd_data_alt, 64'h0000_0001_0000_0000);
        do_read(8'h13, M_LOW);
        check("R8 system reg 0x27", rd_data, 64'h0000_0008_0000_0000);
        do_read(8'h13, M_FULL);
        check("R1 system reg 0x26", rd_data, 64'h0);
    endtask

    task automatic t_even_lane();
        do_write(8'h02, M_FULL, 64'hAAAA_0000_1234_5678);
        do_read(8'h02, M_FULL);
        check("R2 even read", rd_data, 64'h0000_0000_1234_5678);
        do_read(8'h02, M_HIGH);
        check("R10 upper mask fallback", rd_data, 64'h0000_0000_1234_5678);
        do_read(8'h02, M_LOW);
        check("R4 odd untouched by even write", rd_data, 64'h0);
    endtask

    task automatic t_odd_lane();
        do_write(8'h03, M_LOW, 64'hCAFE_0001_FFFF_FFFF);
        do_read(8'h03, M_LOW);
        check("R3 odd read", rd_data, 64'hCAFE_0001_0000_0000);
        do_read(8'h03, M_FULL);
        check("R3 even untouched by odd write", rd_data, 64'h0);
    endtask

    task automatic t_merge();
        do_write(8'h02, M_FULL, 64'h0000_0000_0F0F_0000);
        do_read(8'h02, M_FULL);
        check("R4 OR merge", rd_data, 64'h0000_0000_1F3F_5678);
        do_write(8'h02, M_FULL, 64'h0);
        do_read(8'h02, M_FULL);
        check("R5 zeros do not clear", rd_data, 64'h0000_0000_1F3F_5678);
        do_write(8'h13, M_LOW, 64'h0000_0001_0000_0000);
        do_read(8'h13, M_LOW);
        check("R8 merge onto preset", rd_data, 64'h0000_0009_0000_0000);
    endtask

    task automatic t_hold();
        do_read(8'h03, M_LOW);
        check("R6 read result", rd_data, 64'hCAFE_0001_0000_0000);
        do_write(8'h03, M_LOW, 64'h0000_0010_0000_0000);
        @(negedge clk); word_off = 8'h00; lane_mask = M_FULL;
        @(negedge clk);
        check("R6 holds while idle", rd_data, 64'hCAFE_0001_0000_0000);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        word_off = 8'h02; lane_mask = M_FULL; wr_data = 64'h0000_0000_8000_0000;
        wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R11 old value returned", rd_data, 64'h0000_0000_1F3F_5678);
        do_read(8'h02, M_FULL);
        check("R11 write took effect", rd_data, 64'h0000_0000_9F3F_5678);
    endtask

    task automatic t_out_of_range();
        do_write(8'h40, M_FULL, M_FULL);
        do_write(8'hFF, M_LOW, M_FULL);
        do_read(8'h40, M_FULL);
        check("R7 out of range read", rd_data, 64'h0);
        do_read(8'hFF, M_LOW);
        check("R7 top offset read", rd_data, 64'h0);
        do_read(8'h00, M_FULL);
        check("R7 no alias reg0", rd_data, 64'h0);
        do_read(8'h3F, M_LOW);
        check("R7 no alias reg127", rd_data, 64'h0);
    endtask

    task automatic t_rereset();
        apply_reset();
        check("R1 rd_data cleared", rd_data, 64'h0);
        do_read(8'h02, M_FULL);
        check("R1 sticky bits cleared", rd_data, 64'h0);
        do_read(8'h13, M_LOW);
        check("R8 preset restored", rd_data, 64'h0000_0008_0000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_values();
        t_even_lane();
        t_odd_lane();
        t_merge();
        t_hold();
        t_same_cycle();
        t_out_of_range();
        t_rereset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule